// File: doc/BRIEF.md
# Set-Features Configuration Controller

This block sits behind the command decoder of a parallel-ATA style storage device. When the host issues a set-features command, it interprets the feature code byte and the sector-count parameter byte. It then updates the device's transfer configuration: the narrow (8-bit) data bus option, the write cache, the PIO and DMA transfer modes with the IORDY flow-control enable, and the advanced power-management level. The configuration registers drive the bus timing, cache and power logic that sit around it.

Capability straps give the highest PIO, Multiword DMA and Ultra DMA mode the device supports, and which DMA families exist at all. A further strap says whether the device currently runs in a card-style interface, where Multiword DMA is not allowed. Every accepted command ends with a one-cycle completion pulse. A rejected command also raises the abort flag in that cycle and leaves all configuration untouched. Turning the write cache off is special: the block raises a flush request and stays busy until the cache logic reports that the flush is done. Only then does it signal completion.

Top module: `xfer_feature_unit`

## Requirements
- R1: After reset the block holds PIO mode 0 with IORDY enabled, no DMA mode (dmaKind 00), the 16-bit bus, write cache on, power level FEh, and busy, done, abort and flushReq all low.
- R2: Feature 01h sets byteMode and 81h clears it. io16Suppress is high exactly while byteMode is high.
- R3: Feature 02h sets wrCacheEn and completes in the cycle after acceptance.
- R4: Feature 82h clears wrCacheEn and raises busy and flushReq in the cycle after acceptance. Both stay high until flushDone is sampled high. done rises in the cycle after that sample, with busy and flushReq low.
- R5: For feature 03h, sector count bits 7:3 are the type and bits 2:0 the mode. Type 00000b with mode 000b selects PIO 0 with IORDY on. Type 00000b with mode 001b selects PIO 0 with IORDY off. Type 00001b selects that PIO mode with IORDY on. IORDY is therefore always on for PIO mode 3 and above.
- R6: A PIO, Multiword or Ultra DMA mode number equal to the strapped maximum is accepted. A number above it aborts.
- R7: Type 00100b selects Multiword DMA (dmaKind 01) and type 01000b selects Ultra DMA (dmaKind 10). Each selection replaces the other, so at most one DMA family is ever selected.
- R8: A Multiword DMA request aborts while cardIfMode is high or mwSupported is low. An Ultra DMA request aborts while ultraSupported is low.
- R9: Every other type value aborts. Type 00000b with a mode number of 2 to 7 also aborts.
- R10: Feature 05h loads apmLevel from the sector count for values 01h to FEh. The values 00h and FFh abort.
- R11: An unknown feature code aborts. An aborted command leaves every configuration output unchanged, and abort is high only together with done.
- R12: cmdValid is ignored while busy is high. Such a command changes no configuration and produces no done.
- R13: done, and abort where it applies, last exactly one cycle and appear in the cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| featCode | input | 8 | Feature code byte |
| sectCnt | input | 8 | Sector-count parameter byte |
| maxPioMode | input | 3 | Highest supported PIO mode |
| maxMwMode | input | 3 | Highest supported Multiword DMA mode |
| maxUltraMode | input | 3 | Highest supported Ultra DMA mode |
| mwSupported | input | 1 | Multiword DMA exists |
| ultraSupported | input | 1 | Ultra DMA exists |
| cardIfMode | input | 1 | Card-style interface active |
| flushDone | input | 1 | Cache flush finished |
| byteMode | output | 1 | 8-bit data transfers enabled |
| io16Suppress | output | 1 | Suppress the 16-bit I/O indication on data accesses |
| wrCacheEn | output | 1 | Write cache enabled |
| flushReq | output | 1 | Flush request to the cache logic |
| pioMode | output | 3 | Selected PIO mode |
| iordyEn | output | 1 | IORDY flow control enabled |
| dmaKind | output | 2 | 00 none, 01 Multiword, 10 Ultra |
| dmaMode | output | 3 | Selected DMA mode number |
| apmLevel | output | 8 | Power-management level |
| busy | output | 1 | Command in progress (flush pending) |
| done | output | 1 | Completion pulse |
| abort | output | 1 | Rejection flag, with done |

## Verification
The bench builds the block with its default parameters: a reset power level of FEh and an IORDY threshold of PIO mode 3. It drives the straps with a PIO maximum of 4, a Multiword maximum of 2 and an Ultra maximum of 5, so that every mode-boundary case falls on both sides of a limit. It then drops the card-interface and support straps one at a time to reach each DMA rejection path. A pending flush is held for several cycles while a command is offered, which exposes both the busy hold and the ignored command.

// File: rtl/xfer_feature_pkg.sv
package xfer_feature_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;
  localparam int TYPE_W = BYTE_W - MODE_W;

  localparam logic [BYTE_W-1:0] FC_NARROW_ON  = 8'h01;
  localparam logic [BYTE_W-1:0] FC_NARROW_OFF = 8'h81;
  localparam logic [BYTE_W-1:0] FC_CACHE_ON   = 8'h02;
  localparam logic [BYTE_W-1:0] FC_CACHE_OFF  = 8'h82;
  localparam logic [BYTE_W-1:0] FC_XFER_MODE  = 8'h03;
  localparam logic [BYTE_W-1:0] FC_POWER_LVL  = 8'h05;

  localparam logic [TYPE_W-1:0] XT_PIO_DEF  = 5'b00000;
  localparam logic [TYPE_W-1:0] XT_PIO_FLOW = 5'b00001;
  localparam logic [TYPE_W-1:0] XT_MWDMA    = 5'b00100;
  localparam logic [TYPE_W-1:0] XT_ULTRA    = 5'b01000;

  localparam logic [BYTE_W-1:0] APM_LOW_RSV  = 8'h00;
  localparam logic [BYTE_W-1:0] APM_HIGH_RSV = 8'hFF;

  typedef enum logic [1:0] {
    DMA_NONE  = 2'b00,
    DMA_MW    = 2'b01,
    DMA_ULTRA = 2'b10
  } dmaKind_e;

  // strobes from control to the configuration datapath
  typedef struct packed {
    logic              narrowOn;
    logic              narrowOff;
    logic              cacheOn;
    logic              cacheOff;
    logic              loadPio;
    logic              loadMw;
    logic              loadUltra;
    logic              loadApm;
    logic              iordyVal;
    logic [MODE_W-1:0] modeVal;
    logic [BYTE_W-1:0] apmVal;
  } cfgUpd_t;
endpackage

// File: rtl/xfer_feature_ctrl.sv
module xfer_feature_ctrl
  import xfer_feature_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [BYTE_W-1:0] featCode,
  input  logic [BYTE_W-1:0] sectCnt,
  input  logic [MODE_W-1:0] maxPioMode,
  input  logic [MODE_W-1:0] maxMwMode,
  input  logic [MODE_W-1:0] maxUltraMode,
  input  logic              mwSupported,
  input  logic              ultraSupported,
  input  logic              cardIfMode,
  input  logic              flushDone,
  output cfgUpd_t           upd,
  output logic              flushing,
  output logic              done,
  output logic              abort
);
  logic              accept;
  logic              reject;
  logic              startFlush;
  logic [TYPE_W-1:0] xType;
  logic [MODE_W-1:0] xMode;
  cfgUpd_t           dec;

  assign accept = cmdValid && !flushing;
  assign xType  = sectCnt[BYTE_W-1:MODE_W];
  assign xMode  = sectCnt[MODE_W-1:0];

  always_comb begin
    dec         = '0;
    reject      = 1'b0;
    dec.modeVal = xMode;
    dec.apmVal  = sectCnt;
    unique case (featCode)
      FC_NARROW_ON:  dec.narrowOn  = 1'b1;
      FC_NARROW_OFF: dec.narrowOff = 1'b1;
      FC_CACHE_ON:   dec.cacheOn   = 1'b1;
      FC_CACHE_OFF:  dec.cacheOff  = 1'b1;
      FC_POWER_LVL: begin
        if (sectCnt == APM_LOW_RSV || sectCnt == APM_HIGH_RSV) reject = 1'b1;
        else dec.loadApm = 1'b1;
      end
      FC_XFER_MODE: begin
        unique case (xType)
          XT_PIO_DEF: begin
            if (xMode > 3'd1) reject = 1'b1;
            else begin
              dec.loadPio  = 1'b1;
              dec.iordyVal = (xMode == 3'd0);
              dec.modeVal  = '0;
            end
          end
          XT_PIO_FLOW: begin
            if (xMode > maxPioMode) reject = 1'b1;
            else begin
              dec.loadPio  = 1'b1;
              dec.iordyVal = 1'b1;
            end
          end
          XT_MWDMA: begin
            if (cardIfMode || !mwSupported || xMode > maxMwMode) reject = 1'b1;
            else dec.loadMw = 1'b1;
          end
          XT_ULTRA: begin
            if (!ultraSupported || xMode > maxUltraMode) reject = 1'b1;
            else dec.loadUltra = 1'b1;
          end
          default: reject = 1'b1;
        endcase
      end
      default: reject = 1'b1;
    endcase
  end

  always_comb begin
    upd = dec;
    if (!accept || reject) begin
      upd.narrowOn  = 1'b0;
      upd.narrowOff = 1'b0;
      upd.cacheOn   = 1'b0;
      upd.cacheOff  = 1'b0;
      upd.loadPio   = 1'b0;
      upd.loadMw    = 1'b0;
      upd.loadUltra = 1'b0;
      upd.loadApm   = 1'b0;
    end
  end

  assign startFlush = accept && !reject && dec.cacheOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushing <= 1'b0;
      done     <= 1'b0;
      abort    <= 1'b0;
    end else begin
      abort <= accept && reject;
      if (flushing) begin
        flushing <= !flushDone;
        done     <= flushDone;
      end else begin
        flushing <= startFlush;
        done     <= accept && !startFlush;
      end
    end
  end

  // R11: abort never appears without completion
  p_abort_with_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> done);
  // R4: flush acknowledgement ends the busy phase with completion
  p_flush_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flushing && flushDone) |=> (done && !flushing && !abort));
  // R12: busy phase holds while no acknowledgement arrives
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (flushing && !flushDone) |=> (flushing && !done));
endmodule

// File: rtl/xfer_feature_dp.sv
module xfer_feature_dp
  import xfer_feature_pkg::*;
#(
  parameter logic [7:0] APM_RESET_LVL = 8'hFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgUpd_t           upd,
  output logic              byteMode,
  output logic              wrCacheEn,
  output logic [MODE_W-1:0] pioMode,
  output logic              iordyEn,
  output logic [1:0]        dmaKind,
  output logic [MODE_W-1:0] dmaMode,
  output logic [BYTE_W-1:0] apmLevel
);
  dmaKind_e dmaKindQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteMode  <= 1'b0;
      wrCacheEn <= 1'b1;
      pioMode   <= '0;
      iordyEn   <= 1'b1;
      dmaKindQ  <= DMA_NONE;
      dmaMode   <= '0;
      apmLevel  <= APM_RESET_LVL;
    end else begin
      if (upd.narrowOn)  byteMode  <= 1'b1;
      if (upd.narrowOff) byteMode  <= 1'b0;
      if (upd.cacheOn)   wrCacheEn <= 1'b1;
      if (upd.cacheOff)  wrCacheEn <= 1'b0;
      if (upd.loadPio) begin
        pioMode <= upd.modeVal;
        iordyEn <= upd.iordyVal;
      end
      if (upd.loadMw) begin
        dmaKindQ <= DMA_MW;
        dmaMode  <= upd.modeVal;
      end
      if (upd.loadUltra) begin
        dmaKindQ <= DMA_ULTRA;
        dmaMode  <= upd.modeVal;
      end
      if (upd.loadApm) apmLevel <= upd.apmVal;
    end
  end

  assign dmaKind = dmaKindQ;

  // R7: at most one DMA family held
  p_dma_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmaKind != 2'b11);
  // R10: reserved levels never stored
  p_apm_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    (apmLevel != APM_LOW_RSV) && (apmLevel != APM_HIGH_RSV));
endmodule

// File: rtl/xfer_feature_unit.sv
module xfer_feature_unit
  import xfer_feature_pkg::*;
#(
  parameter logic [7:0] APM_RESET_LVL = 8'hFE,
  parameter int         IORDY_PIO_MIN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] featCode,
  input  logic [7:0] sectCnt,
  input  logic [2:0] maxPioMode,
  input  logic [2:0] maxMwMode,
  input  logic [2:0] maxUltraMode,
  input  logic       mwSupported,
  input  logic       ultraSupported,
  input  logic       cardIfMode,
  input  logic       flushDone,
  output logic       byteMode,
  output logic       io16Suppress,
  output logic       wrCacheEn,
  output logic       flushReq,
  output logic [2:0] pioMode,
  output logic       iordyEn,
  output logic [1:0] dmaKind,
  output logic [2:0] dmaMode,
  output logic [7:0] apmLevel,
  output logic       busy,
  output logic       done,
  output logic       abort
);
  cfgUpd_t upd;
  logic    flushing;

  xfer_feature_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cmdValid       (cmdValid),
    .featCode       (featCode),
    .sectCnt        (sectCnt),
    .maxPioMode     (maxPioMode),
    .maxMwMode      (maxMwMode),
    .maxUltraMode   (maxUltraMode),
    .mwSupported    (mwSupported),
    .ultraSupported (ultraSupported),
    .cardIfMode     (cardIfMode),
    .flushDone      (flushDone),
    .upd            (upd),
    .flushing       (flushing),
    .done           (done),
    .abort          (abort)
  );

  xfer_feature_dp #(.APM_RESET_LVL(APM_RESET_LVL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .upd       (upd),
    .byteMode  (byteMode),
    .wrCacheEn (wrCacheEn),
    .pioMode   (pioMode),
    .iordyEn   (iordyEn),
    .dmaKind   (dmaKind),
    .dmaMode   (dmaMode),
    .apmLevel  (apmLevel)
  );

  assign io16Suppress = byteMode;
  assign busy         = flushing;
  assign flushReq     = flushing;

  // R11: a rejected command leaves configuration untouched
  p_cfg_hold_on_abort_r11: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> ($stable(pioMode) && $stable(iordyEn) && $stable(dmaKind) &&
               $stable(dmaMode) && $stable(apmLevel) && $stable(byteMode) &&
               $stable(wrCacheEn)));
  // R5: IORDY stays on at and above the threshold mode
  p_iordy_high_pio_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pioMode) >= IORDY_PIO_MIN) |-> iordyEn);
  // R8: Multiword DMA never newly selected from a card-style interface
  p_no_mw_card_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaKind == DMA_MW && $past(dmaKind) != DMA_MW) |-> !$past(cardIfMode));
  // R4: cache is off throughout a flush
  p_cache_off_flush_r4: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !wrCacheEn);
endmodule

// File: tb/tb_xfer_feature_unit.sv
module tb_xfer_feature_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] featCode = '0;
  logic [7:0] sectCnt = '0;
  logic [2:0] maxPioMode = 3'd4;
  logic [2:0] maxMwMode = 3'd2;
  logic [2:0] maxUltraMode = 3'd5;
  logic       mwSupported = 1'b1;
  logic       ultraSupported = 1'b1;
  logic       cardIfMode = 1'b0;
  logic       flushDone = 1'b0;
  logic       byteMode, io16Suppress, wrCacheEn, flushReq, iordyEn;
  logic       busy, done, abort;
  logic [2:0] pioMode, dmaMode;
  logic [1:0] dmaKind;
  logic [7:0] apmLevel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  xfer_feature_unit dut (.*);

  typedef struct packed {
    logic [7:0] req;
    logic [7:0] fc;
    logic [7:0] sc;
    logic       ab;
    logic [2:0] pio;
    logic       io;
    logic [1:0] dk;
    logic [2:0] dm;
    logic [7:0] apm;
    logic       bm;
    logic       wc;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  8'h01, 8'h00, 1'b0, 3'd0, 1'b1, 2'b00, 3'd0, 8'hFE, 1'b1, 1'b1}, // R2 on
    '{8'd2,  8'h81, 8'h00, 1'b0, 3'd0, 1'b1, 2'b00, 3'd0, 8'hFE, 1'b0, 1'b1}, // R2 off
    '{8'd5,  8'h03, 8'h01, 1'b0, 3'd0, 1'b0, 2'b00, 3'd0, 8'hFE, 1'b0, 1'b1}, // R5 no IORDY
    '{8'd6,  8'h03, 8'h0C, 1'b0, 3'd4, 1'b1, 2'b00, 3'd0, 8'hFE, 1'b0, 1'b1}, // R6 pio at max
    '{8'd6,  8'h03, 8'h0D, 1'b1, 3'd4, 1'b1, 2'b00, 3'd0, 8'hFE, 1'b0, 1'b1}, // R6 pio over
    '{8'd7,  8'h03, 8'h22, 1'b0, 3'd4, 1'b1, 2'b01, 3'd2, 8'hFE, 1'b0, 1'b1}, // R7 MW2
    '{8'd6,  8'h03, 8'h23, 1'b1, 3'd4, 1'b1, 2'b01, 3'd2, 8'hFE, 1'b0, 1'b1}, // R6 MW over
    '{8'd7,  8'h03, 8'h45, 1'b0, 3'd4, 1'b1, 2'b10, 3'd5, 8'hFE, 1'b0, 1'b1}, // R7 UDMA5
    '{8'd6,  8'h03, 8'h46, 1'b1, 3'd4, 1'b1, 2'b10, 3'd5, 8'hFE, 1'b0, 1'b1}, // R6 UDMA over
    '{8'd7,  8'h03, 8'h20, 1'b0, 3'd4, 1'b1, 2'b01, 3'd0, 8'hFE, 1'b0, 1'b1}, // R7 back to MW
    '{8'd9,  8'h03, 8'h10, 1'b1, 3'd4, 1'b1, 2'b01, 3'd0, 8'hFE, 1'b0, 1'b1}, // R9 type 2
    '{8'd9,  8'h03, 8'h80, 1'b1, 3'd4, 1'b1, 2'b01, 3'd0, 8'hFE, 1'b0, 1'b1}, // R9 type 16
    '{8'd9,  8'h03, 8'h02, 1'b1, 3'd4, 1'b1, 2'b01, 3'd0, 8'hFE, 1'b0, 1'b1}, // R9 default m2
    '{8'd5,  8'h03, 8'h00, 1'b0, 3'd0, 1'b1, 2'b01, 3'd0, 8'hFE, 1'b0, 1'b1}, // R5 default
    '{8'd5,  8'h03, 8'h0B, 1'b0, 3'd3, 1'b1, 2'b01, 3'd0, 8'hFE, 1'b0, 1'b1}, // R5 flow 3
    '{8'd10, 8'h05, 8'h00, 1'b1, 3'd3, 1'b1, 2'b01, 3'd0, 8'hFE, 1'b0, 1'b1}, // R10 00h
    '{8'd10, 8'h05, 8'hFF, 1'b1, 3'd3, 1'b1, 2'b01, 3'd0, 8'hFE, 1'b0, 1'b1}, // R10 FFh
    '{8'd10, 8'h05, 8'h01, 1'b0, 3'd3, 1'b1, 2'b01, 3'd0, 8'h01, 1'b0, 1'b1}, // R10 01h
    '{8'd10, 8'h05, 8'h80, 1'b0, 3'd3, 1'b1, 2'b01, 3'd0, 8'h80, 1'b0, 1'b1}, // R10 80h
    '{8'd11, 8'h44, 8'h00, 1'b1, 3'd3, 1'b1, 2'b01, 3'd0, 8'h80, 1'b0, 1'b1}, // R11 unknown
    '{8'd3,  8'h02, 8'h00, 1'b0, 3'd3, 1'b1, 2'b01, 3'd0, 8'h80, 1'b0, 1'b1}  // R3
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] f, input logic [7:0] s);
    @(negedge clk);
    featCode = f;
    sectCnt  = s;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  function automatic logic [21:0] cfgNow();
    return {pioMode, iordyEn, dmaKind, dmaMode, apmLevel, byteMode, wrCacheEn};
  endfunction

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      finish();
    end
  end

  initial begin
    logic [21:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfgNow() == {3'd0, 1'b1, 2'b00, 3'd0, 8'hFE, 1'b0, 1'b1}, "R1 config",
        cfgNow(), {3'd0, 1'b1, 2'b00, 3'd0, 8'hFE, 1'b0, 1'b1});
    chk({busy, done, abort, flushReq, io16Suppress} == 5'b0, "R1 status",
        {busy, done, abort, flushReq, io16Suppress}, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].fc, VEC[i].sc);
      chk(done == 1'b1, $sformatf("R%0d vec%0d done", VEC[i].req, i), done, 1);
      chk(abort == VEC[i].ab, $sformatf("R%0d vec%0d abort", VEC[i].req, i), abort, VEC[i].ab);
      chk(cfgNow() == {VEC[i].pio, VEC[i].io, VEC[i].dk, VEC[i].dm, VEC[i].apm,
                       VEC[i].bm, VEC[i].wc},
          $sformatf("R%0d vec%0d config", VEC[i].req, i), cfgNow(),
          {VEC[i].pio, VEC[i].io, VEC[i].dk, VEC[i].dm, VEC[i].apm, VEC[i].bm, VEC[i].wc});
    end

    // R13 done/abort last one cycle
    @(negedge clk);
    chk({done, abort} == 2'b00, "R13 pulse ends", {done, abort}, 0);

    // R2 suppression follows narrow mode
    issue(8'h01, 8'h00);
    chk(io16Suppress == 1'b1, "R2 suppress on", io16Suppress, 1);
    issue(8'h81, 8'h00);
    chk(io16Suppress == 1'b0, "R2 suppress off", io16Suppress, 0);

    // R8 card interface blocks Multiword DMA; Ultra DMA still accepted
    issue(8'h03, 8'h41);
    snap = cfgNow();
    cardIfMode = 1'b1;
    issue(8'h03, 8'h21);
    chk(abort == 1'b1 && cfgNow() == snap, "R8 card MW abort", {abort, cfgNow()}, {1'b1, snap});
    cardIfMode = 1'b0;
    mwSupported = 1'b0;
    issue(8'h03, 8'h20);
    chk(abort == 1'b1 && cfgNow() == snap, "R8 unsupported MW", {abort, cfgNow()}, {1'b1, snap});
    mwSupported = 1'b1;
    ultraSupported = 1'b0;
    issue(8'h03, 8'h40);
    chk(abort == 1'b1 && cfgNow() == snap, "R8 unsupported UDMA", {abort, cfgNow()}, {1'b1, snap});
    ultraSupported = 1'b1;

    // R4 cache disable with flush, R12 command during busy ignored
    issue(8'h82, 8'h00);
    chk({busy, flushReq, wrCacheEn, done} == 4'b1100, "R4 flush start",
        {busy, flushReq, wrCacheEn, done}, 4'b1100);
    issue(8'h01, 8'h00);
    chk(byteMode == 1'b0 && done == 1'b0 && busy == 1'b1, "R12 ignored while busy",
        {byteMode, done, busy}, 3'b001);
    repeat (3) @(negedge clk);
    chk({busy, flushReq, done} == 3'b110, "R4 still flushing", {busy, flushReq, done}, 3'b110);
    flushDone = 1'b1;
    @(negedge clk);
    flushDone = 1'b0;
    chk({busy, flushReq, done, abort} == 4'b0010, "R4 flush complete",
        {busy, flushReq, done, abort}, 4'b0010);
    @(negedge clk);
    chk(done == 1'b0 && byteMode == 1'b0, "R12 no late effect", {done, byteMode}, 0);
    issue(8'h02, 8'h00);
    chk(wrCacheEn == 1'b1 && busy == 1'b0, "R3 cache back on", {wrCacheEn, busy}, 2'b10);

    finish();
  end
endmodule